// File: doc/BRIEF.md
# Flag-prefixed serial word transmitter

This block reports a single short event over one output wire. When an event is seen on a rising clock edge, the line goes high for one flag bit. The six payload bits then follow, most significant first, and the line returns low. The block then waits for the next event. It needs no acknowledge and no external reset between frames.

The payload comes from one of two sources. In address mode it is the number of the lowest-numbered of 64 hit strobes. In word mode it is a 6-bit code presented with a valid pulse. A rate input picks how fast the bits go out. In single-rate mode each bit lasts one clock period. In double-rate mode each bit lasts half a period, so bits change on both clock edges. At 200 MHz a single-rate frame takes 35 ns and a double-rate frame takes 20 ns, which is well inside a 100 ns dead-time budget.

Top module: `flag_serial_tx`

## Requirements
- R1: A frame is one high flag bit followed by the payload bits, sent from the most significant bit (bit 5) down to bit 0.
- R2: With no frame in progress, `ser_out` is low.
- R3: In single-rate mode (`ddr_mode`=0 at the capturing edge), the flag appears after the rising edge that samples the event, and each bit then lasts one full clock period.
- R4: In double-rate mode (`ddr_mode`=1 at the capturing edge), the flag is driven in the high phase that follows the capturing edge and bit 5 in the low phase after it. Each later bit lasts one half period, and the line is low in the half period after bit 0.
- R5: In address mode (`src_word`=0), an event is any high bit of `hit`, and the payload is the index of the lowest-numbered high bit.
- R6: In word mode (`src_word`=1), an event is `word_valid`=1 and the payload is `word_in`. In this mode `hit` is ignored, and `word_in` without `word_valid` starts nothing.
- R7: Events that arrive while a frame is in progress are dropped, not queued.
- R8: The block re-arms by itself. A new event is accepted on the rising edge that ends the frame: 7 cycles after the previous start in single-rate mode and 4 cycles after it in double-rate mode.
- R9: The rate mode is taken at the start of a frame. Changing `ddr_mode` during a frame does not alter that frame.
- R10: An active-low `rst_n` at once aborts any frame and forces the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; in double-rate mode both edges time the bits |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_mode | input | 1 | 0: one bit per cycle, 1: one bit per half cycle |
| src_word | input | 1 | 0: address mode from `hit`, 1: word mode |
| hit | input | 64 | Per-channel peak-found strobes |
| word_in | input | 6 | Code to send in word mode |
| word_valid | input | 1 | Event strobe for word mode |
| ser_out | output | 1 | Serial line |

## Verification
The bench targets several corner cases:
- A hit pattern with several lines high, and the extreme channels 0 and 63. A wrong priority encoder would send the highest index or a corrupt mix of bits.
- Events raised in the middle of a frame. A design that queues or reloads would then send an extra or a truncated frame.
- An event held high without a break. This exposes an off-by-one re-arm, either as a gap between frames or as an overlap.
- The mode flipped mid-frame, and a reset asserted mid-frame. A design that reads the live mode would garble the frame, and one that resumes after reset would send stale bits.

// File: rtl/flag_serial_tx.sv
module flag_serial_tx #(
  parameter int CHANNELS = 64,
  parameter int WORD_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ddr_mode,
  input  logic                src_word,
  input  logic [CHANNELS-1:0] hit,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                word_valid,
  output logic                ser_out
);
  localparam int REM_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] hit_idx;
  logic              any_hit;
  logic              idle, event_in, start;
  logic [WORD_W-1:0] payload;
  logic [WORD_W-1:0] sh;
  logic [REM_W-1:0]  rem;
  logic              mode_q, q_pos, nb, q_neg;

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = CHANNELS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = WORD_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign idle     = (rem == '0);
  assign event_in = src_word ? word_valid : any_hit;
  assign payload  = src_word ? word_in : hit_idx;
  assign start    = idle && event_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      rem    <= '0;
      mode_q <= 1'b0;
      q_pos  <= 1'b0;
      nb     <= 1'b0;
    end else if (start) begin
      mode_q <= ddr_mode;
      q_pos  <= 1'b1;
      if (ddr_mode) begin
        nb  <= payload[WORD_W-1];
        sh  <= payload << 1;
        rem <= REM_W'(WORD_W - 1);
      end else begin
        nb  <= 1'b0;
        sh  <= payload;
        rem <= REM_W'(WORD_W);
      end
    end else if (!idle) begin
      q_pos <= sh[WORD_W-1];
      if (mode_q) begin
        nb  <= (rem >= REM_W'(2)) ? sh[WORD_W-2] : 1'b0;
        sh  <= sh << 2;
        rem <= (rem >= REM_W'(2)) ? rem - REM_W'(2) : '0;
      end else begin
        nb  <= 1'b0;
        sh  <= sh << 1;
        rem <= rem - REM_W'(1);
      end
    end else begin
      q_pos <= 1'b0;
      nb    <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_neg <= 1'b0;
    else        q_neg <= nb;
  end

  assign ser_out = mode_q ? (clk ? q_pos : q_neg) : q_pos;

  // R7: a running frame only counts down, never reloads
  a_r7_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (rem < $past(rem)));

  // R1: flag bit leads every frame
  a_r1_flag_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> q_pos);

  // R5: chosen channel is really hit
  a_r5_winner_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !src_word) |-> hit[hit_idx]);

  // R5: no lower-numbered channel is hit
  a_r5_no_lower_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !src_word) |-> ((hit & ((CHANNELS'(1) << hit_idx) - CHANNELS'(1))) == '0));

  // R8: last pair or bit returns the block to idle
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == REM_W'(1)) |=> idle);

  // R2: idle with no event keeps both half-phase sources low
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !event_in) |=> (!q_pos && !nb));

  // R9: rate mode fixed while a frame runs
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode_q));
endmodule

// File: tb/tb_flag_serial_tx.sv
`timescale 1ns/1ps
module tb_flag_serial_tx;
  localparam int CH = 64;
  localparam int W  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ddr_mode = 1'b0;
  logic          src_word = 1'b0;
  logic [CH-1:0] hit = '0;
  logic [W-1:0]  word_in = '0;
  logic          word_valid = 1'b0;
  logic          ser_out;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string phase = "R10";
  bit    exp_q[$];

  flag_serial_tx #(.CHANNELS(CH), .WORD_W(W)) dut (.*);

  always #2.5 clk = ~clk;

  // Reference model: one queue entry per half period
  always @(posedge clk) begin
    logic          ev;
    logic [W-1:0]  p;
    int            k;
    if (!rst_n) begin
      exp_q.delete();
      exp_q.push_back(1'b0);
      exp_q.push_back(1'b0);
    end else if (exp_q.size() == 0) begin
      if (src_word) begin
        ev = word_valid;
        p  = word_in;
      end else begin
        ev = |hit;
        k = 0;
        while (k < CH && !hit[k]) k++;
        p = W'(k);
      end
      if (!ev) begin
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b0);
      end else if (ddr_mode) begin
        exp_q.push_back(1'b1);
        for (int b = W - 1; b >= 0; b--) exp_q.push_back(p[b]);
        exp_q.push_back(1'b0);
      end else begin
        exp_q.push_back(1'b1);
        exp_q.push_back(1'b1);
        for (int b = W - 1; b >= 0; b--) begin
          exp_q.push_back(p[b]);
          exp_q.push_back(p[b]);
        end
      end
    end
  end

  task automatic chk();
    bit e;
    e = 1'b0;
    if (!rst_n) exp_q.delete();
    else if (exp_q.size() > 0) e = exp_q.pop_front();
    checks++;
    if (ser_out !== e) begin
      fails++;
      $display("FAIL %s t=%0t ser_out=%b expected=%b", phase, $time, ser_out, e);
    end
  endtask

  always @(posedge clk) begin #1.25; if (!done) chk(); end
  always @(negedge clk) begin #1.25; if (!done) chk(); end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w, input logic ddr);
    @(negedge clk);
    src_word = 1'b1; ddr_mode = ddr; word_in = w; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic send_hits(input logic [CH-1:0] m, input logic ddr);
    @(negedge clk);
    src_word = 1'b0; ddr_mode = ddr; hit = m;
    @(negedge clk);
    hit = '0;
  endtask

  initial begin
    #(100000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog t=%0t ser_out=%b expected=frame end", $time, ser_out);
    finish_run();
  end

  initial begin
    // R10: reset state
    phase = "R10";
    gap(3);
    rst_n = 1'b1;
    // R2: idle line low
    phase = "R2";
    gap(4);
    // R3: single-rate timing
    phase = "R3";
    send_word(6'h2D, 1'b0); gap(8);
    // R1: flag then MSB-first payload
    phase = "R1";
    send_word(6'h21, 1'b0); gap(8);
    // R5: lowest-numbered hit wins
    phase = "R5";
    send_hits(64'd1 << 37, 1'b0); gap(8);
    send_hits((64'd1 << 5) | (64'd1 << 9) | (64'd1 << 63), 1'b0); gap(8);
    send_hits(64'd1, 1'b1); gap(5);
    send_hits(64'd1 << 63, 1'b1); gap(5);
    // R4: double-rate timing
    phase = "R4";
    send_word(6'h3F, 1'b1); gap(5);
    send_word(6'h15, 1'b1); gap(5);
    // R6: word mode ignores hit, needs valid
    phase = "R6";
    @(negedge clk); src_word = 1'b1; word_in = 6'h3F; hit = 64'hFFFF;
    gap(3);
    hit = '0;
    send_word(6'h0B, 1'b0); gap(8);
    // R7: events during a frame are dropped
    phase = "R7";
    send_word(6'h0A, 1'b0); gap(1);
    send_word(6'h3F, 1'b0); gap(10);
    send_hits(64'd1 << 20, 1'b1);
    send_hits(64'd1 << 2, 1'b1); gap(6);
    // R8: held event restarts right after each frame
    phase = "R8";
    @(negedge clk); src_word = 1'b1; ddr_mode = 1'b0; word_in = 6'h2A; word_valid = 1'b1;
    gap(16);
    ddr_mode = 1'b1;
    gap(10);
    word_valid = 1'b0;
    gap(8);
    // R9: mode change mid-frame has no effect
    phase = "R9";
    send_word(6'h33, 1'b0);
    ddr_mode = 1'b1; gap(8);
    send_word(6'h0C, 1'b1);
    ddr_mode = 1'b0; gap(6);
    // R10: reset aborts a frame
    phase = "R10";
    send_word(6'h3F, 1'b0); gap(2);
    rst_n = 1'b0; gap(2);
    rst_n = 1'b1; gap(3);
    send_word(6'h12, 1'b1); gap(5);
    finish_run();
  end
endmodule